// File: doc/BRIEF.md
# Recirculating Serial Shift Bank

This block is a serial delay memory of 512 bits in total. The storage is split into one, two or four independent lanes of equal length. Each lane behaves as a first-in-first-out bit line. It has one serial input and one serial output, and its output always shows the oldest bit it holds. All lanes share one clock, and all captures happen on the falling edge of that clock.

A single shared control picks the feed for every lane at once. When the control is low, each lane takes a fresh bit from its own input. When the control is high, each lane writes its own output bit back into itself. In that mode the stored pattern rotates in place and nothing is lost.

The block is used as a loop memory. Data is written in once and then circulated while it is read out serially. Internally each lane is a circular buffer with one shared pointer, and its behaviour matches a plain flip-flop chain bit for bit.

Top module: `recirc_shift_bank`

## Requirements
- R1: The parameter CHANNELS takes the value 1, 2 or 4. Each lane then holds 512/CHANNELS bits, so every configuration stores 512 bits in total.
- R2: All state, including the outputs, is updated only on the falling clock edge. `dout` holds steady through the high phase and the rising edge, even when `din` or `recirc` changes.
- R3: With `recirc` = 0 at a falling edge, each lane captures its own `din` bit. A bit captured at falling edge k appears on that lane's `dout` right after falling edge k+DEPTH-1, so it takes DEPTH edges counting the capture edge.
- R4: With `recirc` = 1 at a falling edge, each lane captures its current `dout` bit, and `din` has no effect on the stored data.
- R5: After DEPTH consecutive recirculating edges, each lane returns to the contents it had before them. The next DEPTH output bits then repeat the sequence of the previous DEPTH.
- R6: The single `recirc` input governs every lane together. No lane can load while another lane recirculates.
- R7: While the clock is held low for any length of time, the stored contents and `dout` do not change.
- R8: A synchronous active-low reset is sampled at the falling edge. It clears every stored bit, so `dout` reads 0 afterwards, and a lane outputs 0 until loaded data has travelled through it.
- R9: The shared ring pointer steps by one on every falling edge outside reset. It wraps from DEPTH-2 to 0 and stays within that range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; capture on falling edge |
| rst_n | input | 1 | Synchronous active-low reset, sampled on falling edge |
| din | input | CHANNELS | Serial input bit of each lane |
| recirc | input | 1 | Shared feed select: 0 load from `din`, 1 write back `dout` |
| dout | output | CHANNELS | Oldest stored bit of each lane, registered |

## Verification
The bench builds the block with CHANNELS = 4, so each lane is 128 bits deep. At that depth a complete pass, a full rotation and many pointer wraps fit in a few hundred edges. With four lanes driven side by side, it also shows that one shared select acts on every lane at the same edge. The one-lane and two-lane variants use the same lane and pointer code with a longer ring, and they differ only in the derived depth and pointer width.

// File: rtl/rsb_pkg.sv
// Shared constants and helpers for the recirculating shift bank.
// Assumes the total storage is fixed and split evenly over the lanes.
package rsb_pkg;

    localparam int RSB_TOTAL_BITS = 512;

    // Feed choice of a lane at a capture edge.
    typedef enum logic {
        FEED_LOAD   = 1'b0,
        FEED_RECIRC = 1'b1
    } feed_e;

    // Depth of one lane for a given lane count.
    function automatic int lane_depth(input int lanes);
        return RSB_TOTAL_BITS / lanes;
    endfunction

    // Pointer width needed to address a ring of the given number of entries.
    function automatic int ring_ptr_width(input int entries);
        return (entries > 1) ? $clog2(entries) : 1;
    endfunction

endpackage

// File: rtl/rsb_ring_ptr.sv
// Shared ring pointer for all lanes.
// Steps once per falling edge and wraps after LAST.
// Assumes every lane advances together, so one pointer serves them all.
module rsb_ring_ptr #(
    parameter int W    = 7,
    parameter int LAST = 126
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] ptr
);

    localparam logic [W-1:0] LAST_V = W'(LAST);

    // Advance the slot index, wrapping at the end of the ring.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ptr == LAST_V) begin
            ptr <= '0;
        end else begin
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/rsb_lane.sv
// One serial lane of DEPTH bits.
// The last stage is the output register, and the other DEPTH-1 stages sit in a ring
// addressed by the shared pointer. Each edge moves the oldest ring entry into the output
// register and writes the new bit into the freed slot, which matches a DEPTH-stage
// flip-flop chain bit for bit.
// Assumes DEPTH >= 2 and that the pointer walks 0..DEPTH-2 in order.
module rsb_lane #(
    parameter int DEPTH = 128,
    parameter int PTR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] ptr,
    input  rsb_pkg::feed_e   feed,
    input  logic             din,
    output logic             dout
);

    localparam int ENTRIES = DEPTH - 1;

    logic [ENTRIES-1:0] ring;
    logic               next_bit;

    // Pick the bit entering the lane: the external input or the lane's own output.
    always_comb begin
        next_bit = (feed == rsb_pkg::FEED_RECIRC) ? dout : din;
    end

    // Move the oldest ring entry to the output and store the new bit in its slot.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            ring <= '0;
            dout <= 1'b0;
        end else begin
            dout       <= ring[ptr];
            ring[ptr]  <= next_bit;
        end
    end

endmodule

// File: rtl/recirc_shift_bank.sv
// Top of the recirculating shift bank.
// It holds CHANNELS lanes of 512/CHANNELS bits, with one shared recirculate select
// and one shared ring pointer.
// Assumes CHANNELS is 1, 2 or 4 and that inputs are steady around the falling edge.
module recirc_shift_bank #(
    parameter int CHANNELS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CHANNELS-1:0] din,
    input  logic                recirc,
    output logic [CHANNELS-1:0] dout
);

    localparam int DEPTH    = rsb_pkg::lane_depth(CHANNELS);
    localparam int ENTRIES  = DEPTH - 1;
    localparam int PTR_W    = rsb_pkg::ring_ptr_width(ENTRIES);
    localparam int PTR_LAST = ENTRIES - 1;

    logic [PTR_W-1:0] ring_ptr;
    rsb_pkg::feed_e   feed_sel;

    // Turn the shared control into the feed choice seen by every lane.
    always_comb begin
        feed_sel = recirc ? rsb_pkg::FEED_RECIRC : rsb_pkg::FEED_LOAD;
    end

    rsb_ring_ptr #(
        .W    (PTR_W),
        .LAST (PTR_LAST)
    ) u_ring_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ptr   (ring_ptr)
    );

    for (genvar c = 0; c < CHANNELS; c++) begin : g_lane
        rsb_lane #(
            .DEPTH (DEPTH),
            .PTR_W (PTR_W)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .ptr   (ring_ptr),
            .feed  (feed_sel),
            .din   (din[c]),
            .dout  (dout[c])
        );
    end

endmodule

// File: rtl/rsb_checker.sv
// Property checker for the recirculating shift bank, bound to the top.
// Assumes capture on the falling edge and a synchronous active-low reset.
module rsb_checker #(
    parameter int CHANNELS = 4,
    parameter int PTR_W    = 7,
    parameter int PTR_LAST = 126
) (
    input logic                clk,
    input logic                rst_n,
    input logic [CHANNELS-1:0] dout,
    input logic [PTR_W-1:0]    ptr
);

    logic                past_ok = 1'b0;
    logic                armed   = 1'b0;
    logic [CHANNELS-1:0] high_val;

    // Mark that at least one falling edge has been seen.
    always_ff @(negedge clk) past_ok <= 1'b1;

    // Record the output at the rising edge so it can be compared over the high phase.
    always_ff @(posedge clk) begin
        armed    <= 1'b1;
        high_val <= dout;
    end

    // R2
    hold_between_edges_chk: assert property (@(negedge clk) disable iff (!rst_n)
        armed |-> dout == high_val);

    // R8
    reset_clears_chk: assert property (@(negedge clk) disable iff (!rst_n)
        past_ok && $past(!rst_n) |-> (dout == '0 && ptr == '0));

    // R9
    ptr_step_chk: assert property (@(negedge clk) disable iff (!rst_n)
        past_ok && $past(rst_n) |->
            ptr == (($past(ptr) == PTR_W'(PTR_LAST)) ? '0 : $past(ptr) + 1'b1));

    // R9
    ptr_range_chk: assert property (@(negedge clk) disable iff (!rst_n)
        ptr <= PTR_W'(PTR_LAST));

endmodule

bind recirc_shift_bank rsb_checker #(
    .CHANNELS (CHANNELS),
    .PTR_W    (PTR_W),
    .PTR_LAST (PTR_LAST)
) u_rsb_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .dout  (dout),
    .ptr   (ring_ptr)
);

// File: tb/test_recirc_shift_bank.sv
// Self-checking bench: random and directed stimulus against a queue model per lane.
module test_recirc_shift_bank;

    localparam int CH         = 4;
    localparam int DEPTH      = 512 / CH;
    localparam int CLK_PERIOD = 10;

    logic          clk     = 1'b0;
    logic          clk_run = 1'b1;
    logic          rst_n   = 1'b0;
    logic [CH-1:0] din     = '0;
    logic          recirc  = 1'b0;
    logic [CH-1:0] dout;

    int checks = 0;
    int fails  = 0;

    // Reference queue per lane: index 0 is newest, index DEPTH-1 is what dout shows.
    logic mdl [CH][DEPTH];
    logic [CH-1:0] rot_a [DEPTH];

    recirc_shift_bank #(.CHANNELS(CH)) i_recirc_shift_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (din),
        .recirc (recirc),
        .dout   (dout)
    );

    // Clock that can be parked low.
    always begin
        #(CLK_PERIOD / 2);
        if (clk_run) clk = ~clk;
    end

    function automatic logic [CH-1:0] exp_out();
        logic [CH-1:0] v;
        for (int c = 0; c < CH; c++) v[c] = mdl[c][DEPTH-1];
        return v;
    endfunction

    task automatic model_edge(input logic [CH-1:0] d, input logic rc, input logic rs);
        for (int c = 0; c < CH; c++) begin
            logic nb;
            nb = rc ? mdl[c][DEPTH-1] : d[c];
            for (int k = DEPTH - 1; k > 0; k--) mdl[c][k] = mdl[c][k-1];
            mdl[c][0] = nb;
            if (!rs) begin
                for (int k = 0; k < DEPTH; k++) mdl[c][k] = 1'b0;
            end
        end
    endtask

    task automatic check_vec(input string req, input logic [CH-1:0] act, input logic [CH-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: dout=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One capture edge; called just after a rising edge.
    task automatic step(input logic [CH-1:0] d, input logic rc, input string req);
        din    = d;
        recirc = rc;
        #(CLK_PERIOD / 4);
        check_vec("R2", dout, exp_out());
        @(negedge clk);
        model_edge(d, rc, rst_n);
        @(posedge clk);
        check_vec(req, dout, exp_out());
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [CH-1:0] snap;
        int            hit_at;
        void'($urandom(32'h5EED));
        for (int c = 0; c < CH; c++)
            for (int k = 0; k < DEPTH; k++) mdl[c][k] = 1'bx;

        // R8: reset clears everything.
        repeat (3) @(negedge clk);
        model_edge('0, 1'b0, 1'b0);
        @(posedge clk);
        rst_n = 1'b1;
        check_vec("R8", dout, '0);

        // R3: random loads over two full passes; first pass reads zeros (R8).
        for (int i = 0; i < 2 * DEPTH; i++) step(CH'($urandom()), 1'b0, (i < DEPTH) ? "R8" : "R3");

        // R4 R5: full rotation with noisy din, then a second one must repeat it.
        for (int i = 0; i < DEPTH; i++) begin
            step(CH'($urandom()), 1'b1, "R4");
            rot_a[i] = dout;
        end
        for (int i = 0; i < DEPTH; i++) begin
            step(CH'($urandom()), 1'b1, "R5");
            check_vec("R5", dout, rot_a[i]);
        end

        // R6 R9: shared select, random mix of load and recirculate over many wraps.
        for (int i = 0; i < 600; i++) step(CH'($urandom()), ($urandom() % 3) == 0, "R6 R9");

        // R7: park the clock low after a capture edge, wiggle inputs, then resume.
        din    = CH'($urandom());
        recirc = 1'b0;
        @(negedge clk);
        model_edge(din, 1'b0, rst_n);
        clk_run = 1'b0;
        #1;
        snap = dout;
        for (int i = 0; i < 50; i++) begin
            #(CLK_PERIOD * 10);
            din    = CH'($urandom());
            recirc = $urandom();
        end
        check_vec("R7", dout, snap);
        check_vec("R7", dout, exp_out());
        clk_run = 1'b1;
        @(posedge clk);
        for (int i = 0; i < DEPTH; i++) step(CH'($urandom()), 1'b0, "R7");

        // R8: reset in mid-run clears the contents.
        rst_n = 1'b0;
        step(CH'($urandom()), 1'b0, "R8");
        rst_n = 1'b1;
        check_vec("R8", dout, '0);

        // R1 R3: a single marker takes exactly 512/CH edges, counting its capture edge.
        hit_at = -1;
        step('1, 1'b0, "R3");
        for (int k = 2; k <= DEPTH + 2; k++) begin
            step('0, 1'b0, "R3");
            if (dout == '1 && hit_at < 0) hit_at = k;
        end
        checks++;
        if (hit_at != DEPTH) begin
            fails++;
            $display("FAIL R1: marker seen after %0d edges expected %0d", hit_at, DEPTH);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule